// File: doc/BRIEF.md
# Dual-Clock FIFO with Occupancy Counters in Each Domain

This block is a first-in first-out buffer between two unrelated clocks. A producer pushes words on the write clock and a consumer takes them on the read clock. The block does not compare pointers across the boundary to find its level. Each side keeps its own count of words held, and the count is the only source of that side's flags. Two binary operation counters address a dual-port register array. Their low bits select the cell and their top bit lets a wrapped count be told apart from an unwrapped one.

Each side publishes a free-running Gray-coded tally of its own accepted operations. The opposite side passes that tally through two flip-flops and converts it back to binary. It then subtracts the value it applied last time, and the difference, which may be more than one, is added to or taken from its count. So the write-side count rises at once on a write and falls late on a read, and it can only over-state the level. The read-side count falls at once on a read and rises late on a write, and it can only under-state the level. That bias is what makes the blocking flags safe: the write side stops at full and the read side stops at empty. The write side's empty flag and the read side's full flag are status only.

The read port shows the head word without a request, and a read pops it. Both resets are asynchronous and are applied together. Each is released after a clock edge of its own domain.

Top module: `xclk_count_fifo`

## Requirements
- R1: While the resets are held, and on release, both counts are 0. Both empty flags and both almost-empty flags are 1, and both full flags and both almost-full flags are 0.
- R2: A write with wr_en=1 while wfull=0 is accepted. It raises wused by one from the next write clock edge and stores wdata.
- R3: A write with wr_en=1 while wfull=1 is ignored. wused does not rise and the word never reaches the read port.
- R4: A read with rd_en=1 while rempty=0 is accepted. It pops the head word and lowers rused by one from the next read clock edge. A read while rempty=1 is ignored and leaves rused and the head unchanged.
- R5: An accepted write reaches rused on the third read clock edge after the write clock edge that accepted it. When both clocks are one signal, that is exactly three cycles later. All writes gathered between two samples are added in a single step.
- R6: An accepted read reaches wused on the third write clock edge after the read clock edge that accepted it, which is exactly three cycles later on a shared clock. Gathered reads are removed in a single step.
- R7: In each domain, full is 1 exactly when that domain's count equals DEPTH. Empty is 1 exactly when that count is 0. The flags follow the count in the same cycle.
- R8: In each domain, almost-full is 1 exactly when the count is at least DEPTH-AF_MARGIN. Almost-empty is 1 exactly when the count is at most AE_MARGIN.
- R9: While rempty=0, rdata shows the oldest accepted word not yet read. Words leave in the order they were accepted.
- R10: With unrelated clock periods, no word is lost or duplicated and neither count exceeds DEPTH. Once traffic stops and both sides have drained, both counts return to 0 and both empty flags return to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write domain clock |
| wrst_n | input | 1 | Write domain reset, asynchronous assert, active low |
| wr_en | input | 1 | Write request |
| wdata | input | DW | Word to store |
| wfull | output | 1 | Write-side full, blocks writes |
| walmost_full | output | 1 | Write-side almost-full |
| wempty | output | 1 | Write-side empty, status only |
| walmost_empty | output | 1 | Write-side almost-empty |
| wused | output | log2(DEPTH)+1 | Write-side count of held words |
| rclk | input | 1 | Read domain clock |
| rrst_n | input | 1 | Read domain reset, asynchronous assert, active low |
| rd_en | input | 1 | Read request (pop head) |
| rdata | output | DW | Head word |
| rempty | output | 1 | Read-side empty, blocks reads |
| ralmost_empty | output | 1 | Read-side almost-empty |
| rfull | output | 1 | Read-side full, status only |
| ralmost_full | output | 1 | Read-side almost-full |
| rused | output | log2(DEPTH)+1 | Read-side count of held words |

## Verification
A local operation changes its own count, and therefore that side's flags, right after the clock edge that accepts it. Its effect on the opposite count arrives three edges of the opposite clock later: two synchronizer stages, then the counter update. rdata moves to the next word in the same cycle as the local count. For the exact-timing phase the bench drives both clocks from one signal and samples every output at the falling edge. It keeps a four-deep history of the cumulative accepted writes and reads, so each expected count is the local total now minus the remote total three cycles back. A second phase runs unrelated clock periods and checks only order, the absence of loss and duplication, and the settled levels, because sampling times across the boundary cannot be predicted there.

// File: rtl/xcf_pkg.sv
`timescale 1ns/1ps
package xcf_pkg;

  typedef struct packed {
    logic full;
    logic almost_full;
    logic empty;
    logic almost_empty;
  } level_t;

  // Flags of one domain, from that domain's own count only.
  function automatic level_t levels(input int unsigned used, input int unsigned depth,
                                    input int unsigned af_m, input int unsigned ae_m);
    level_t l;
    l.full         = (used == depth);
    l.empty        = (used == 0);
    l.almost_full  = (used + af_m >= depth);
    l.almost_empty = (used <= ae_m);
    return l;
  endfunction

endpackage

// File: rtl/xcf_ram.sv
`timescale 1ns/1ps
module xcf_ram #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned CELLS = 1 << AW;

  logic [DW-1:0] cells [CELLS];

  always_ff @(posedge wclk)
    if (we) cells[waddr] <= wdata;

  // Head word is shown without a request.
  assign rdata = cells[raddr];
endmodule

// File: rtl/xcf_domain.sv
`timescale 1ns/1ps
module xcf_domain #(
  parameter int unsigned AW        = 4,
  parameter int unsigned AF_MARGIN = 2,
  parameter int unsigned AE_MARGIN = 2,
  parameter bit          COUNT_UP  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_req,
  input  logic [AW:0]     far_gray,
  output logic [AW-1:0]   addr,
  output logic [AW:0]     near_gray,
  output logic [AW:0]     used,
  output logic            op_fire,
  output logic [AW:0]     far_delta,
  output xcf_pkg::level_t lvl
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  typedef logic [PW-1:0] ptr_t;

  function automatic ptr_t bin_to_gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray_to_bin(input ptr_t g);
    ptr_t b;
    b[PW-1] = g[PW-1];
    for (int i = int'(PW) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  ptr_t ops_q, ops_nx, sync1_q, sync2_q, seen_q, far_bin, used_nx, fire_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ops_q     <= '0;
      near_gray <= '0;
      sync1_q   <= '0;
      sync2_q   <= '0;
      seen_q    <= '0;
      used      <= '0;
    end else begin
      ops_q     <= ops_nx;
      near_gray <= bin_to_gray(ops_nx);
      sync1_q   <= far_gray;
      sync2_q   <= sync1_q;
      seen_q    <= far_bin;
      used      <= used_nx;
    end
  end

  assign lvl       = xcf_pkg::levels(32'(used), DEPTH, AF_MARGIN, AE_MARGIN);
  assign far_bin   = gray_to_bin(sync2_q);
  assign far_delta = far_bin - seen_q;
  assign fire_v    = ptr_t'(op_fire);
  assign ops_nx    = ops_q + fire_v;
  assign addr      = ops_q[AW-1:0];

  generate
    if (COUNT_UP) begin : g_fill_side
      assign op_fire = op_req & ~lvl.full;
      assign used_nx = used + fire_v - far_delta;
    end else begin : g_drain_side
      assign op_fire = op_req & ~lvl.empty;
      assign used_nx = used - fire_v + far_delta;
    end
  endgenerate
endmodule

// File: rtl/xclk_count_fifo.sv
`timescale 1ns/1ps
module xclk_count_fifo #(
  parameter int unsigned DW        = 8,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned AF_MARGIN = 2,
  parameter int unsigned AE_MARGIN = 2
) (
  input  logic                     wclk,
  input  logic                     wrst_n,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wdata,
  output logic                     wfull,
  output logic                     walmost_full,
  output logic                     wempty,
  output logic                     walmost_empty,
  output logic [$clog2(DEPTH):0]   wused,
  input  logic                     rclk,
  input  logic                     rrst_n,
  input  logic                     rd_en,
  output logic [DW-1:0]            rdata,
  output logic                     rempty,
  output logic                     ralmost_empty,
  output logic                     rfull,
  output logic                     ralmost_full,
  output logic [$clog2(DEPTH):0]   rused
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wdelta, rdelta;
  logic          w_fire, r_fire;
  xcf_pkg::level_t wlvl, rlvl;

  xcf_domain #(.AW(AW), .AF_MARGIN(AF_MARGIN), .AE_MARGIN(AE_MARGIN), .COUNT_UP(1'b1)) u_wside (
    .clk(wclk), .rst_n(wrst_n), .op_req(wr_en), .far_gray(rgray),
    .addr(waddr), .near_gray(wgray), .used(wused), .op_fire(w_fire),
    .far_delta(wdelta), .lvl(wlvl)
  );

  xcf_domain #(.AW(AW), .AF_MARGIN(AF_MARGIN), .AE_MARGIN(AE_MARGIN), .COUNT_UP(1'b0)) u_rside (
    .clk(rclk), .rst_n(rrst_n), .op_req(rd_en), .far_gray(wgray),
    .addr(raddr), .near_gray(rgray), .used(rused), .op_fire(r_fire),
    .far_delta(rdelta), .lvl(rlvl)
  );

  xcf_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wclk), .we(w_fire), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  assign wfull         = wlvl.full;
  assign walmost_full  = wlvl.almost_full;
  assign wempty        = wlvl.empty;
  assign walmost_empty = wlvl.almost_empty;
  assign rfull         = rlvl.full;
  assign ralmost_full  = rlvl.almost_full;
  assign rempty        = rlvl.empty;
  assign ralmost_empty = rlvl.almost_empty;
endmodule

// File: rtl/xclk_count_fifo_chk.sv
`timescale 1ns/1ps
module xclk_count_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input logic        wclk,
  input logic        wrst_n,
  input logic        wr_en,
  input logic        wfull,
  input logic [AW:0] wused,
  input logic [AW:0] wdelta,
  input logic        rclk,
  input logic        rrst_n,
  input logic        rd_en,
  input logic        rempty,
  input logic [AW:0] rused,
  input logic [AW:0] rdelta
);
  localparam logic [AW+1:0] LIMIT = (AW+2)'(DEPTH);

  p_wused_bound_r10: assert property (@(posedge wclk) disable iff (!wrst_n)
    {1'b0, wused} <= LIMIT);

  p_rused_bound_r10: assert property (@(posedge rclk) disable iff (!rrst_n)
    {1'b0, rused} <= LIMIT);

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && wfull) |=> (wused <= $past(wused)));

  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && rempty) |=> (rused >= $past(rused)));

  p_wused_step_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    1'b1 |=> ({1'b0, wused} <= {1'b0, $past(wused)} + 1'b1));

  p_rused_step_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    1'b1 |=> ({1'b0, rused} + 1'b1 >= {1'b0, $past(rused)}));

  p_read_report_r6: assert property (@(posedge wclk) disable iff (!wrst_n)
    {1'b0, wdelta} <= LIMIT);

  p_write_report_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    {1'b0, rdelta} <= LIMIT);
endmodule

bind xclk_count_fifo xclk_count_fifo_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wfull(wfull), .wused(wused), .wdelta(wdelta),
  .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rempty(rempty), .rused(rused), .rdelta(rdelta)
);

// File: tb/xclk_count_fifo_tb_top.sv
`timescale 1ns/1ps
module xclk_count_fifo_tb_top;
  localparam int DW = 8, DEPTH = 16, AFM = 3, AEM = 2, CW = $clog2(DEPTH) + 1;
  localparam int N_ASYNC = 240;

  logic clk_a = 1'b0, clk_b = 1'b0, async_mode = 1'b0;
  always #2 clk_a = ~clk_a;   // 250 MHz
  always #3 clk_b = ~clk_b;

  logic wclk, rclk;
  assign wclk = clk_a;
  assign rclk = async_mode ? clk_b : clk_a;

  logic wrst_n = 1'b0, rrst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0, rdata;
  logic wfull, walmost_full, wempty, walmost_empty, rempty, ralmost_empty, rfull, ralmost_full;
  logic [CW-1:0] wused, rused;

  xclk_count_fifo #(.DW(DW), .DEPTH(DEPTH), .AF_MARGIN(AFM), .AE_MARGIN(AEM)) dut_i (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wdata(wdata),
    .wfull(wfull), .walmost_full(walmost_full), .wempty(wempty), .walmost_empty(walmost_empty),
    .wused(wused), .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rdata(rdata),
    .rempty(rempty), .ralmost_empty(ralmost_empty), .rfull(rfull), .ralmost_full(ralmost_full),
    .rused(rused)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] rng_a = 32'h1bad_5eed, rng_b = 32'h0c0f_fee1;
  int wh [4];
  int rh [4];
  bit blk_w = 1'b0, blk_r = 1'b0;

  function automatic logic [DW-1:0] word(input int n);
    return DW'((n * 37 + 11) & 255);
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int flag4(input int used);
    return {28'd0, used == DEPTH, used == 0, used + AFM >= DEPTH, used <= AEM};
  endfunction

  // One shared-clock cycle: compare state after the last edge, then pick inputs.
  task automatic step(input int wp, input int rp);
    int wu, ru;
    bit aw, ar;
    @(negedge clk_a);
    wu = wh[0] - rh[3];
    ru = wh[3] - rh[0];
    check_eq(blk_w ? "R3" : "R2 R6", "wused", int'(wused), wu);
    check_eq(blk_r ? "R4" : "R4 R5", "rused", int'(rused), ru);
    check_eq("R7", "write full/empty", int'({wfull, wempty}), flag4(wu) >> 2);
    check_eq("R7", "read full/empty", int'({rfull, rempty}), flag4(ru) >> 2);
    check_eq("R8", "write almost flags", int'({walmost_full, walmost_empty}), flag4(wu) & 3);
    check_eq("R8", "read almost flags", int'({ralmost_full, ralmost_empty}), flag4(ru) & 3);
    if (ru > 0) check_eq("R9", "rdata head", int'(rdata), int'(word(rh[0])));
    rng_a ^= rng_a << 13; rng_a ^= rng_a >> 17; rng_a ^= rng_a << 5;
    wr_en = (int'(rng_a[15:0]) % 100) < wp;
    rd_en = (int'(rng_a[31:16]) % 100) < rp;
    wdata = word(wh[0]);
    aw = wr_en && (wu < DEPTH);
    ar = rd_en && (ru > 0);
    blk_w = wr_en && !aw;
    blk_r = rd_en && !ar;
    for (int i = 3; i > 0; i--) begin
      wh[i] = wh[i-1];
      rh[i] = rh[i-1];
    end
    wh[0] += int'(aw);
    rh[0] += int'(ar);
  endtask

  task automatic segment(input int cycles, input int wp, input int rp);
    for (int c = 0; c < cycles; c++) step(wp, rp);
  endtask

  initial begin
    int sent, recv;
    repeat (3) @(negedge clk_a);
    // R1: reset state
    check_eq("R1", "wused", int'(wused), 0);
    check_eq("R1", "rused", int'(rused), 0);
    check_eq("R1", "write flags", int'({wfull, wempty, walmost_full, walmost_empty}), 5);
    check_eq("R1", "read flags", int'({rfull, rempty, ralmost_full, ralmost_empty}), 5);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin wh[i] = 0; rh[i] = 0; end

    segment(1, 100, 0);     // single write, latency to rused (R5)
    segment(6, 0, 0);
    segment(1, 0, 100);     // single read, latency to wused (R6)
    segment(6, 0, 0);
    segment(30, 100, 0);    // fill and push against full (R3)
    segment(6, 0, 0);
    segment(30, 0, 100);    // drain and pull against empty (R4)
    segment(200, 50, 50);
    segment(200, 85, 30);
    segment(200, 30, 85);
    segment(100, 100, 100);
    segment(40, 0, 100);
    segment(6, 0, 0);

    // Unrelated clocks: order and settling (R10)
    @(negedge clk_a);
    wr_en = 1'b0; rd_en = 1'b0;
    wrst_n = 1'b0; rrst_n = 1'b0;
    repeat (2) @(negedge clk_a);
    async_mode = 1'b1;
    repeat (4) @(negedge clk_a);
    wrst_n = 1'b1;
    @(negedge clk_b);
    rrst_n = 1'b1;
    sent = 0;
    recv = 0;
    fork
      begin
        while (sent < N_ASYNC) begin
          @(negedge clk_a);
          rng_a ^= rng_a << 13; rng_a ^= rng_a >> 17; rng_a ^= rng_a << 5;
          wr_en = rng_a[0] | rng_a[1];
          wdata = word(sent);
          if (wr_en && !wfull) sent++;
        end
        @(negedge clk_a);
        wr_en = 1'b0;
      end
      begin
        while (recv < N_ASYNC) begin
          @(negedge clk_b);
          rng_b ^= rng_b << 13; rng_b ^= rng_b >> 17; rng_b ^= rng_b << 5;
          rd_en = rng_b[2] | (rng_b[3] & rng_b[4]);
          if (rd_en && !rempty) begin
            check_eq("R9 R10", "async word order", int'(rdata), int'(word(recv)));
            recv++;
          end
        end
        @(negedge clk_b);
        rd_en = 1'b0;
      end
    join
    repeat (12) @(negedge clk_b);
    check_eq("R10", "settled wused", int'(wused), 0);
    check_eq("R10", "settled rused", int'(rused), 0);
    check_eq("R10", "settled empties", int'({wempty, rempty}), 3);
    check_eq("R10", "settled fulls", int'({wfull, rfull}), 0);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
    end
  end
endmodule